// File: doc/BRIEF.md
# Converter Control Register and Channel Sequencer

This block is the digital control core of a serial-bus data converter. It watches byte-level events from a two-wire serial slave front end. It decides whether an address byte selects this device, and it loads the control byte that follows into a control register. From that register it drives the analog-output enable, the input-mode selection, the active channel number and the oscillator controls.

When auto-increment is set, the channel steps forward on every conversion-done pulse. It wraps to channel 0 after the highest channel that the current input mode allows. A requested channel beyond that highest channel is clamped to it. Two bits, one in each nibble of the control byte, together choose between oscillator halving and a monitor output that carries the oscillator divided by four.

The byte input carries only a valid strobe and never applies back-pressure. Every byte presented with `byte_vld` high is consumed in that same cycle, so no ready signal exists. All other pins are plain level or pulse signals.

Top module: `cvt_ctrl_seq`

## Requirements
- R1: A byte with `byte_idx` = 0 selects the device only when bits 7:1 equal 1,0,1,1,1,strap[1],strap[0] and bit 0 (write flag) is 0. Any other address byte leaves the device deselected, and a following control byte then changes no output.
- R2: While selected, a byte with `byte_idx` = 1 is loaded into the control register, and the outputs reflect it one cycle after the capturing edge. Bytes with `byte_idx` of 2 or more are ignored. A `bus_start` pulse deselects the device.
- R3: The control byte layout is as follows. Bit 6 is the analog-output enable (`aout_en`). Bits 5:4 are the input mode. Bit 2 is auto-increment. Bits 1:0 are the requested channel. Bits 7 and 3 are the oscillator controls.
- R4: The highest channel per mode is 3 for mode 00, 2 for mode 01, 2 for mode 10 and 1 for mode 11. A requested channel above it is replaced by it, so `chan` never exceeds the current mode's maximum.
- R5: A `conv_done` pulse with auto-increment set moves `chan` to `chan`+1 on the next cycle, or to 0 from the highest channel. Without auto-increment `chan` is unchanged. A control write in the same cycle takes precedence over the step.
- R6: After reset `chan`, `in_mode`, `aout_en`, `osc_en`, `osc_half` and `osc_mon` are all 0.
- R7: `osc_en` is high when bit 6 is 1, or when bit 3 is 1 and bit 7 is 0.
- R8: `osc_half` is high exactly when bits 7 and 3 are both 1.
- R9: With bit 3 = 1 and bit 7 = 0, a 2-bit divider counts `osc_tick` pulses from 0 and `osc_mon` is high while the count is 2 or 3, giving a period of four ticks. Otherwise `osc_mon` is low and the divider is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | STRAP_W | Low address bits set by board straps |
| bus_start | input | 1 | Start condition seen on the bus (pulse) |
| byte_vld | input | 1 | A received byte is presented this cycle |
| byte_idx | input | IDX_W | Position of the byte in the transaction, 0 = address |
| byte_dat | input | 8 | Received byte |
| conv_done | input | 1 | One A/D conversion finished (pulse) |
| osc_tick | input | 1 | One internal oscillator period elapsed (pulse) |
| chan | output | 2 | Active input channel |
| in_mode | output | 2 | Input-mode selection |
| aout_en | output | 1 | Analog output and DAC enable; low means high-impedance |
| osc_en | output | 1 | Internal oscillator enable |
| osc_half | output | 1 | Select half the internal oscillator frequency |
| osc_mon | output | 1 | Oscillator divided by four, or low |

## Verification
Every result of this block appears one cycle after the rising edge that captures the stimulus. This applies to a control byte, a `conv_done` pulse, a `bus_start` pulse and an `osc_tick`. The driver raises an input at a falling edge, lowers it at the next falling edge, and then pushes the expected output word. The monitor compares that word a quarter period after the following rising edge. The driver keeps all inputs idle through that whole cycle, so the sampled outputs cannot already carry the next stimulus.

// File: rtl/cvt_ctrl_pkg.sv
package cvt_ctrl_pkg;

  localparam int CH_W = 2;

  typedef enum logic [1:0] {
    MODE_SE4   = 2'b00,
    MODE_DIFF3 = 2'b01,
    MODE_MIX   = 2'b10,
    MODE_DIFF2 = 2'b11
  } in_mode_e;

  // Field order follows the bit positions of the control byte, msb first.
  typedef struct packed {
    logic            osc_hi;
    logic            aout_en;
    in_mode_e        mode;
    logic            osc_lo;
    logic            auto_inc;
    logic [CH_W-1:0] chan;
  } ctrl_t;

  function automatic logic [CH_W-1:0] mode_max(input in_mode_e m);
    case (m)
      MODE_SE4:   mode_max = 2'd3;
      MODE_DIFF3: mode_max = 2'd2;
      MODE_MIX:   mode_max = 2'd2;
      default:    mode_max = 2'd1;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] clamp_chan(input logic [CH_W-1:0] req,
                                                 input in_mode_e m);
    clamp_chan = (req > mode_max(m)) ? mode_max(m) : req;
  endfunction

endpackage

// File: rtl/cvt_addr_match.sv
module cvt_addr_match #(
  parameter int STRAP_W = 2,
  parameter int IDX_W   = 2,
  localparam int BASE_W = 7 - STRAP_W,
  parameter logic [BASE_W-1:0] ADDR_BASE = 5'b10111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               bus_start,
  input  logic               byte_vld,
  input  logic [IDX_W-1:0]   byte_idx,
  input  logic [7:0]         byte_dat,
  output logic               ctrl_wr
);

  logic       sel_q;
  logic       is_addr;
  logic       hit;
  logic [6:0] own_addr;

  assign own_addr = {ADDR_BASE, strap};
  assign is_addr  = byte_vld && (byte_idx == '0);
  assign hit      = (byte_dat[7:1] == own_addr) && !byte_dat[0];

  always_ff @(posedge clk) begin
    if (!rst_n)         sel_q <= 1'b0;
    else if (is_addr)   sel_q <= hit;
    else if (bus_start) sel_q <= 1'b0;
  end

  assign ctrl_wr = sel_q && byte_vld && (byte_idx == IDX_W'(1));

  AST_MISS_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_addr && (byte_dat[7:1] != own_addr || byte_dat[0])) |=> !ctrl_wr || !sel_q); // R1

  AST_START_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !is_addr) |=> !sel_q); // R2

  AST_LATE_BYTE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_idx > IDX_W'(1)) |-> !ctrl_wr); // R2

endmodule

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
  import cvt_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdat,
  input  logic       conv_done,
  output ctrl_t      ctrl_q
);

  ctrl_t           wr_val;
  logic [CH_W-1:0] top_ch;
  logic [CH_W-1:0] next_ch;
  logic            step;

  always_comb begin
    wr_val      = ctrl_t'(wdat);
    wr_val.chan = clamp_chan(wdat[1:0], in_mode_e'(wdat[5:4]));
  end

  assign top_ch  = mode_max(ctrl_q.mode);
  assign next_ch = (ctrl_q.chan >= top_ch) ? '0 : ctrl_q.chan + 1'b1;
  assign step    = conv_done && ctrl_q.auto_inc;

  always_ff @(posedge clk) begin
    if (!rst_n)    ctrl_q      <= '0;
    else if (wr)   ctrl_q      <= wr_val;
    else if (step) ctrl_q.chan <= next_ch;
  end

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.chan <= mode_max(ctrl_q.mode)); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr && ctrl_q.chan == top_ch) |=> ctrl_q.chan == '0); // R5

  AST_HOLD_NO_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !ctrl_q.auto_inc && !wr) |=> $stable(ctrl_q)); // R5

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl_q.aout_en == $past(wdat[6])) && (ctrl_q.mode == $past(wdat[5:4]))); // R3

endmodule

// File: rtl/cvt_osc_ctl.sv
module cvt_osc_ctl #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_hi,
  input  logic osc_lo,
  input  logic aout_en,
  input  logic osc_tick,
  output logic osc_en,
  output logic osc_half,
  output logic osc_mon
);

  logic                mon_sel;
  logic [DIV_LOG2-1:0] div_q;

  assign mon_sel  = osc_lo && !osc_hi;
  assign osc_half = osc_lo && osc_hi;
  assign osc_en   = aout_en || mon_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (!mon_sel) div_q <= '0;
    else if (osc_tick) div_q <= div_q + 1'b1;
  end

  assign osc_mon = mon_sel && div_q[DIV_LOG2-1];

  AST_MON_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_sel |-> !osc_mon); // R9

  AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel && !osc_tick) |=> $stable(div_q)); // R9

  AST_MON_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mon |-> osc_en); // R7

endmodule

// File: rtl/cvt_ctrl_seq.sv
module cvt_ctrl_seq
  import cvt_ctrl_pkg::*;
#(
  parameter int STRAP_W  = 2,
  parameter int IDX_W    = 2,
  parameter int DIV_LOG2 = 2,
  localparam int BASE_W  = 7 - STRAP_W,
  parameter logic [BASE_W-1:0] ADDR_BASE = 5'b10111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               bus_start,
  input  logic               byte_vld,
  input  logic [IDX_W-1:0]   byte_idx,
  input  logic [7:0]         byte_dat,
  input  logic               conv_done,
  input  logic               osc_tick,
  output logic [1:0]         chan,
  output logic [1:0]         in_mode,
  output logic               aout_en,
  output logic               osc_en,
  output logic               osc_half,
  output logic               osc_mon
);

  logic  ctrl_wr;
  ctrl_t ctrl_q;

  cvt_addr_match #(
    .STRAP_W  (STRAP_W),
    .IDX_W    (IDX_W),
    .ADDR_BASE(ADDR_BASE)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap),
    .bus_start(bus_start),
    .byte_vld (byte_vld),
    .byte_idx (byte_idx),
    .byte_dat (byte_dat),
    .ctrl_wr  (ctrl_wr)
  );

  cvt_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wdat     (byte_dat),
    .conv_done(conv_done),
    .ctrl_q   (ctrl_q)
  );

  cvt_osc_ctl #(
    .DIV_LOG2(DIV_LOG2)
  ) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_hi  (ctrl_q.osc_hi),
    .osc_lo  (ctrl_q.osc_lo),
    .aout_en (ctrl_q.aout_en),
    .osc_tick(osc_tick),
    .osc_en  (osc_en),
    .osc_half(osc_half),
    .osc_mon (osc_mon)
  );

  assign chan    = ctrl_q.chan;
  assign in_mode = ctrl_q.mode;
  assign aout_en = ctrl_q.aout_en;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (chan == '0) && !aout_en && !osc_en && !osc_half && !osc_mon); // R6

endmodule

// File: tb/cvt_ctrl_seq_test.sv
module cvt_ctrl_seq_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b01;
  logic       bus_start = 1'b0;
  logic       byte_vld = 1'b0;
  logic [1:0] byte_idx = 2'd0;
  logic [7:0] byte_dat = 8'h00;
  logic       conv_done = 1'b0;
  logic       osc_tick = 1'b0;
  logic [1:0] chan, in_mode;
  logic       aout_en, osc_en, osc_half, osc_mon;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [8:0] v;
    string      tag;
  } item_t;
  item_t q[$];

  // Bench model built from the requirements.
  bit       m_sel = 1'b0;
  bit [7:0] m_ctrl = 8'h00;
  bit [1:0] m_chan = 2'd0;
  int       m_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_ctrl_seq uut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .bus_start(bus_start),
    .byte_vld(byte_vld), .byte_idx(byte_idx), .byte_dat(byte_dat),
    .conv_done(conv_done), .osc_tick(osc_tick), .chan(chan),
    .in_mode(in_mode), .aout_en(aout_en), .osc_en(osc_en),
    .osc_half(osc_half), .osc_mon(osc_mon)
  );

  function automatic bit [1:0] top_of(input bit [1:0] mode);
    case (mode)
      2'b00: top_of = 2'd3;
      2'b01: top_of = 2'd2;
      2'b10: top_of = 2'd2;
      default: top_of = 2'd1;
    endcase
  endfunction

  function automatic bit mon_on();
    mon_on = m_ctrl[3] && !m_ctrl[7];
  endfunction

  function automatic logic [8:0] model_word();
    bit en, half, mon;
    en   = m_ctrl[6] || mon_on();
    half = m_ctrl[7] && m_ctrl[3];
    mon  = mon_on() && (m_div >= 2);
    model_word = {m_chan, m_ctrl[5:4], m_ctrl[6], en, half, mon, 1'b0};
  endfunction

  task automatic expect_now(input string tag);
    item_t it;
    it.v = model_word();
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [1:0] idx, input logic [7:0] d, input bit done);
    @(negedge clk);
    byte_vld = 1'b1; byte_idx = idx; byte_dat = d; conv_done = done;
    @(negedge clk);
    byte_vld = 1'b0; conv_done = 1'b0;
    if (idx == 2'd0) m_sel = (d[7:1] == {5'b10111, strap}) && !d[0];
    else if (idx == 2'd1 && m_sel) begin
      m_ctrl = d;
      m_chan = (d[1:0] > top_of(d[5:4])) ? top_of(d[5:4]) : d[1:0];
      if (!mon_on()) m_div = 0;
    end else if (done && m_ctrl[2])
      m_chan = (m_chan >= top_of(m_ctrl[5:4])) ? 2'd0 : m_chan + 2'd1;
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
    m_sel = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] a, input logic [7:0] c, input bit done,
                            input string tag);
    pulse_start();
    put_byte(2'd0, a, 1'b0);
    put_byte(2'd1, c, done);
    expect_now(tag);
  endtask

  task automatic pulse_done(input string tag);
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    if (m_ctrl[2]) m_chan = (m_chan >= top_of(m_ctrl[5:4])) ? 2'd0 : m_chan + 2'd1;
    expect_now(tag);
  endtask

  task automatic pulse_tick(input string tag);
    @(negedge clk); osc_tick = 1'b1;
    @(negedge clk); osc_tick = 1'b0;
    if (mon_on()) m_div = (m_div + 1) % 4;
    expect_now(tag);
  endtask

  // Monitor: pops one expectation per cycle and compares it.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it = q.pop_front();
        act = {chan, in_mode, aout_en, osc_en, osc_half, osc_mon, 1'b0};
        checks++;
        if (act !== it.v) begin
          errors++;
          $display("FAIL %s: outputs actual=%b expected=%b (chan,mode,aout,osc_en,half,mon,0)",
                   it.tag, act, it.v);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R6 reset state");

    // R1: foreign address and read flag both leave the device deselected
    write_ctrl(8'hB8, 8'h43, 1'b0, "R1 other strap address ignored");
    write_ctrl(8'hBB, 8'h43, 1'b0, "R1 read-flag address ignored");
    // R2, R3: own address, control loaded
    write_ctrl(8'hBA, 8'h43, 1'b0, "R2 R3 control byte loaded");
    put_byte(2'd2, 8'h00, 1'b0);
    expect_now("R2 third byte ignored");
    pulse_start();
    put_byte(2'd1, 8'h00, 1'b0);
    expect_now("R2 start deselects");

    // R4: clamp in each mode
    write_ctrl(8'hBA, 8'h53, 1'b0, "R4 mode01 ch3 clamps to 2");
    write_ctrl(8'hBA, 8'h63, 1'b0, "R4 mode10 ch3 clamps to 2");
    write_ctrl(8'hBA, 8'h72, 1'b0, "R4 mode11 ch2 clamps to 1");
    write_ctrl(8'hBA, 8'h71, 1'b0, "R4 mode11 ch1 kept");
    write_ctrl(8'hBA, 8'h03, 1'b0, "R4 mode00 ch3 kept");

    // R5: auto-increment and wrap
    write_ctrl(8'hBA, 8'h54, 1'b0, "R5 autoinc start");
    for (int i = 0; i < 4; i++) pulse_done("R5 autoinc step mode01");
    write_ctrl(8'hBA, 8'h77, 1'b0, "R5 R4 autoinc mode11 clamped");
    pulse_done("R5 wrap to 0 from clamped top");
    write_ctrl(8'hBA, 8'h41, 1'b0, "R5 no autoinc");
    pulse_done("R5 no autoinc holds");
    write_ctrl(8'hBA, 8'h54, 1'b0, "R5 autoinc reload");
    write_ctrl(8'hBA, 8'h56, 1'b1, "R5 write wins over step");

    // R7, R8: oscillator controls
    write_ctrl(8'hBA, 8'h88, 1'b0, "R8 R7 half without enable");
    write_ctrl(8'hBA, 8'hC8, 1'b0, "R8 R7 half with output enable");
    write_ctrl(8'hBA, 8'h80, 1'b0, "R8 bit7 alone no half");

    // R9: monitor divide by four
    write_ctrl(8'hBA, 8'h08, 1'b0, "R9 R7 monitor selected");
    for (int i = 0; i < 8; i++) pulse_tick("R9 monitor divide by 4");
    write_ctrl(8'hBA, 8'h88, 1'b0, "R9 monitor off");
    pulse_tick("R9 monitor stays low");
    write_ctrl(8'hBA, 8'h08, 1'b0, "R9 divider restarts");
    pulse_tick("R9 first tick low");
    pulse_tick("R9 second tick high");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule